// File: doc/BRIEF.md
# Single-Channel DMA Bus Controller

This block lets one peripheral move a block of words to or from memory while the CPU stays out of the data path. Software loads a start address, a word count and a direction through a register port and pulses a start command. The controller then waits for the peripheral to ask for service, requests the system bus from the CPU, and, once the CPU grants it, turns the bus switches over to the DMA side. It then drives the memory address and grants the peripheral direct access to memory, one word per cycle.

While it owns the bus, the controller steps the address up by one and the remaining count down by one for each word moved. If the peripheral withdraws its request partway through, the controller holds the bus and the address until the request comes back. After the last word it drops the bus request, puts the switches back to the CPU side, raises a done flag, and waits for the CPU to withdraw its grant before it returns to idle.

Top module: `dma_bus_ctrl`

## Requirements
- R1: After reset the block is idle: `sw_cpu`=1, `sw_dma_addr`=0, `sw_dma_data`=0, `cpu_breq`=0, `per_gnt`=0, `mem_we`=0, `done`=0, `busy`=0.
- R2: After a start with a nonzero count, `busy` is 1 and `cpu_breq` stays 0 until `per_req` is seen high at a clock edge. After that edge `cpu_breq` is 1.
- R3: The DMA switches (`sw_dma_addr`, `sw_dma_data`) and `per_gnt` stay 0 until `cpu_bgnt` is sampled high. From the edge after that sample, both DMA switches are 1 and `sw_cpu` is 0.
- R4: While the bus is held, `per_gnt` equals `per_req` in the same cycle. `mem_addr` equals the start address plus the number of words already moved. `mem_we` is 1 exactly when `per_gnt` is 1 and the direction input `cfg_dir` was 1 (1 = peripheral writes memory, 0 = peripheral reads memory).
- R5: At the edge that moves the final word, `cpu_breq` drops to 0, `sw_cpu` returns to 1, both DMA switches return to 0, and `done` becomes 1.
- R6: After completion, `busy` stays 1 for as long as `cpu_bgnt` stays 1. At the first edge where `cpu_bgnt` is sampled 0, `busy` becomes 0.
- R7: If `per_req` is 0 while the bus is held, `per_gnt` is 0 and `mem_we` is 0. `cpu_breq` and the DMA switches stay 1, and `mem_addr` keeps its value.
- R8: A start accepted while idle clears `done` at that edge when the count is nonzero.
- R9: A start with a count of zero sets `done` at that edge, leaves `busy` at 0 and never asserts `cpu_breq`.
- R10: `cfg_start` is ignored while `busy` is 1. The running block's addresses and word count are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Start command pulse, taken only while idle |
| cfg_addr | input | ADDR_W | Start address of the block |
| cfg_count | input | CNT_W | Number of words to move |
| cfg_dir | input | 1 | 1: peripheral writes memory, 0: peripheral reads memory |
| per_req | input | 1 | Transfer request from the peripheral |
| per_gnt | output | 1 | Transfer grant to the peripheral |
| cpu_breq | output | 1 | Bus request to the CPU |
| cpu_bgnt | input | 1 | Bus grant from the CPU |
| sw_cpu | output | 1 | Enable of the CPU-side bus switch |
| sw_dma_addr | output | 1 | Enable of the DMA address-path switch |
| sw_dma_data | output | 1 | Enable of the DMA data-path switch |
| mem_addr | output | ADDR_W | Memory address driven during the transfer |
| mem_we | output | 1 | Memory write enable |
| done | output | 1 | Block complete flag |
| busy | output | 1 | Controller is not idle |

## Verification
Each sampled input takes effect one edge later. A start moves `busy` and `done` at the next edge. A request seen at an edge raises `cpu_breq` after it, a grant seen at an edge flips the switches after it, and the last moved word drops `cpu_breq` and sets `done` after its edge. `per_gnt` and `mem_we` follow `per_req` in the same cycle. The bench drives inputs on falling edges and checks registered results at the next falling edge. For the same-cycle outputs it checks a short delay after the drive. Each scenario task walks the handshake in this fixed order and compares each word's address with the start address plus the word index.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ARMED   = 3'd1,
        ST_REQ     = 3'd2,
        ST_XFER    = 3'd3,
        ST_RELEASE = 3'd4
    } dma_state_e;

    typedef struct packed {
        logic cpu_path;
        logic dma_addr_path;
        logic dma_data_path;
    } bus_sw_t;

    function automatic bus_sw_t switches_for(input dma_state_e st);
        bus_sw_t s;
        if (st == ST_XFER) begin
            s.cpu_path      = 1'b0;
            s.dma_addr_path = 1'b1;
            s.dma_data_path = 1'b1;
        end else begin
            s.cpu_path      = 1'b1;
            s.dma_addr_path = 1'b0;
            s.dma_data_path = 1'b0;
        end
        return s;
    endfunction

    function automatic logic holds_bus_request(input dma_state_e st);
        return (st == ST_REQ) || (st == ST_XFER);
    endfunction

endpackage

// File: rtl/dma_walk.sv
module dma_walk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last_word
);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr   <= '0;
            remain <= '0;
        end else if (load) begin
            addr   <= load_addr;
            remain <= load_cnt;
        end else if (step) begin
            addr   <= addr + ADDR_ONE;
            remain <= remain - CNT_ONE;
        end
    end

    assign last_word = (remain == CNT_ONE);
endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       count_zero,
    input  logic       per_req,
    input  logic       bgnt,
    input  logic       last_word,
    output dma_state_e state,
    output logic       load,
    output logic       step,
    output logic       done
);
    dma_state_e nxt;
    logic       finish;

    assign load   = start && (state == ST_IDLE);
    assign step   = (state == ST_XFER) && per_req;
    assign finish = step && last_word;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (load && !count_zero) nxt = ST_ARMED;
            ST_ARMED:   if (per_req)             nxt = ST_REQ;
            ST_REQ:     if (bgnt)                nxt = ST_XFER;
            ST_XFER:    if (finish)              nxt = ST_RELEASE;
            ST_RELEASE: if (!bgnt)               nxt = ST_IDLE;
            default:                             nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            if (load)        done <= count_zero;
            else if (finish) done <= 1'b1;
        end
    end
endmodule

// File: rtl/dma_bus_ctrl.sv
module dma_bus_ctrl
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_start,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              cfg_dir,
    input  logic              per_req,
    output logic              per_gnt,
    output logic              cpu_breq,
    input  logic              cpu_bgnt,
    output logic              sw_cpu,
    output logic              sw_dma_addr,
    output logic              sw_dma_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              done,
    output logic              busy
);
    dma_state_e state;
    logic       load, step, last_word, dir_q;
    bus_sw_t    sw;

    dma_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (cfg_start),
        .count_zero (cfg_count == '0),
        .per_req    (per_req),
        .bgnt       (cpu_bgnt),
        .last_word  (last_word),
        .state      (state),
        .load       (load),
        .step       (step),
        .done       (done)
    );

    dma_walk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_addr (cfg_addr),
        .load_cnt  (cfg_count),
        .step      (step),
        .addr      (mem_addr),
        .last_word (last_word)
    );

    always_ff @(posedge clk) begin
        if (rst)       dir_q <= 1'b0;
        else if (load) dir_q <= cfg_dir;
    end

    assign sw          = switches_for(state);
    assign sw_cpu      = sw.cpu_path;
    assign sw_dma_addr = sw.dma_addr_path;
    assign sw_dma_data = sw.dma_data_path;
    assign cpu_breq    = holds_bus_request(state);
    assign per_gnt     = step;
    assign mem_we      = step && dir_q;
    assign busy        = (state != ST_IDLE);
endmodule

// File: rtl/dma_bus_ctrl_chk.sv
module dma_bus_ctrl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              per_req,
    input logic              per_gnt,
    input logic              cpu_breq,
    input logic              cpu_bgnt,
    input logic              sw_cpu,
    input logic              sw_dma_addr,
    input logic              sw_dma_data,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              done,
    input logic              busy
);
    // R2
    breq_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_breq) |-> $past(per_req));

    // R3
    switch_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_dma_data) |-> $past(cpu_bgnt) && cpu_breq);

    // R3
    gnt_needs_bus_chk: assert property (@(posedge clk) disable iff (rst)
        per_gnt |-> sw_dma_addr && sw_dma_data && !sw_cpu && cpu_breq);

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        per_gnt |=> mem_addr == $past(mem_addr) + ADDR_W'(1));

    // R4
    we_only_granted_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> per_gnt && per_req);

    // R5
    release_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_breq) |-> done && sw_cpu && !sw_dma_data);

    // R6
    wait_grant_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cpu_bgnt && !cpu_breq && done) |=> busy);

    // R7
    pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_dma_data && !per_gnt) |=> $stable(mem_addr) && cpu_breq);
endmodule

bind dma_bus_ctrl dma_bus_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .per_req     (per_req),
    .per_gnt     (per_gnt),
    .cpu_breq    (cpu_breq),
    .cpu_bgnt    (cpu_bgnt),
    .sw_cpu      (sw_cpu),
    .sw_dma_addr (sw_dma_addr),
    .sw_dma_data (sw_dma_data),
    .mem_addr    (mem_addr),
    .mem_we      (mem_we),
    .done        (done),
    .busy        (busy)
);

// File: tb/dma_bus_ctrl_test.sv
`timescale 1ns/1ps
module dma_bus_ctrl_test;
    localparam int AW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_start;
    logic [AW-1:0] cfg_addr;
    logic [CW-1:0] cfg_count;
    logic          cfg_dir;
    logic          per_req;
    logic          per_gnt;
    logic          cpu_breq;
    logic          cpu_bgnt;
    logic          sw_cpu, sw_dma_addr, sw_dma_data;
    logic [AW-1:0] mem_addr;
    logic          mem_we, done, busy;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    dma_bus_ctrl #(.ADDR_W(AW), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_addr(cfg_addr),
        .cfg_count(cfg_count), .cfg_dir(cfg_dir), .per_req(per_req),
        .per_gnt(per_gnt), .cpu_breq(cpu_breq), .cpu_bgnt(cpu_bgnt),
        .sw_cpu(sw_cpu), .sw_dma_addr(sw_dma_addr), .sw_dma_data(sw_dma_data),
        .mem_addr(mem_addr), .mem_we(mem_we), .done(done), .busy(busy)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic start_cmd(input logic [AW-1:0] a, input logic [CW-1:0] n,
                             input logic d);
        cfg_addr = a; cfg_count = n; cfg_dir = d; cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; cfg_start = 1'b0; cfg_addr = '0; cfg_count = '0;
        cfg_dir = 1'b0; per_req = 1'b0; cpu_bgnt = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1", "switches", {29'd0, sw_cpu, sw_dma_addr, sw_dma_data}, 32'b100);
        check("R1", "breq/gnt/we", {29'd0, cpu_breq, per_gnt, mem_we}, 32'b000);
        check("R1", "done/busy", {30'd0, done, busy}, 32'b00);
    endtask

    // Full block; pause_at >= n means no pause; poke_start tests R10
    task automatic t_block(input logic [AW-1:0] base, input int n, input logic d,
                           input int pause_at, input bit poke_start);
        start_cmd(base, CW'(n), d);
        // R8
        check("R8", "done cleared by start", {31'd0, done}, 0);
        check("R2", "busy after start", {31'd0, busy}, 1);
        @(negedge clk);
        check("R2", "no breq before per_req", {31'd0, cpu_breq}, 0);
        per_req = 1'b1;
        @(negedge clk);
        check("R2", "breq after per_req", {31'd0, cpu_breq}, 1);
        @(negedge clk);
        // R3
        check("R3", "no dma switch before grant", {30'd0, sw_dma_addr, sw_dma_data}, 0);
        check("R3", "no per_gnt before grant", {31'd0, per_gnt}, 0);
        cpu_bgnt = 1'b1;
        @(negedge clk);
        check("R3", "switches after grant", {29'd0, sw_cpu, sw_dma_addr, sw_dma_data}, 32'b011);
        for (int i = 0; i < n; i++) begin
            if (i == pause_at) begin
                per_req = 1'b0;
                #1;
                // R7
                check("R7", "per_gnt in pause", {30'd0, per_gnt, mem_we}, 0);
                @(negedge clk);
                check("R7", "addr held", 32'(mem_addr), 32'(base + AW'(i)));
                check("R7", "bus held", {30'd0, cpu_breq, sw_dma_data}, 32'b11);
                per_req = 1'b1;
                #1;
            end
            // R4
            check("R4", "mem_addr", 32'(mem_addr), 32'(base + AW'(i)));
            check("R4", "per_gnt/we", {30'd0, per_gnt, mem_we}, {30'd0, 1'b1, d});
            if (poke_start && i == 0) begin
                cfg_addr = base + AW'(16'h0100); cfg_count = 8'd1; cfg_start = 1'b1;
            end
            @(negedge clk);
            cfg_start = 1'b0;
        end
        per_req = 1'b0;
        // R5
        check("R5", "breq dropped", {31'd0, cpu_breq}, 0);
        check("R5", "switches restored", {29'd0, sw_cpu, sw_dma_addr, sw_dma_data}, 32'b100);
        check("R5", "done set", {31'd0, done}, 1);
        @(negedge clk);
        @(negedge clk);
        // R6
        check("R6", "busy while grant held", {31'd0, busy}, 1);
        cpu_bgnt = 1'b0;
        @(negedge clk);
        check("R6", "idle after grant drop", {31'd0, busy}, 0);
        if (poke_start)
            // R10
            check("R10", "final addr unaffected", 32'(mem_addr), 32'(base + AW'(n)));
    endtask

    task automatic t_zero();
        start_cmd(16'h0400, 8'd0, 1'b1);
        // R9
        check("R9", "done at once", {31'd0, done}, 1);
        check("R9", "not busy", {31'd0, busy}, 0);
        per_req = 1'b1;
        repeat (2) @(negedge clk);
        check("R9", "no breq", {31'd0, cpu_breq}, 0);
        per_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_block(16'h1000, 4, 1'b1, 99, 1'b0);
        t_block(16'h2FFE, 5, 1'b0, 2, 1'b0);
        t_zero();
        t_block(16'h0040, 3, 1'b1, 1, 1'b1);
        t_block(16'hFFFF, 1, 1'b0, 99, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule